// File: doc/BRIEF.md
# USB Endpoint Command Interpreter

This block sits between a local microcontroller and a USB device core. The microcontroller writes command bytes through a byte-wide port. The block decodes each byte and runs any data phase that follows it. Two commands are handled. The validate command marks the IN buffer as holding data ready to send. The frame command returns the 11-bit frame number from the most recent good SOF packet.

The serial engine delivers two pulses. The first is an SOF pulse, with the frame number valid in the same cycle. The second is a pulse when an IN token has been served from the buffer. The frame number is sent back low byte first. The microcontroller may stop after the first byte or go on to read the second. The block takes a copy of the frame number when the command is accepted, so an SOF that arrives between the two reads cannot mix bytes from two different frames.

Top module: `usb_cmd_interp`

## Requirements
- R1: After reset, buf_full_o is 0 and rd_data_o is 0, and the stored frame number is 0.
- R2: Command byte 0xFA sets buf_full_o from the cycle after the strobe. It opens no data phase, so rd_data_o stays 0.
- R3: An in_served_i pulse clears buf_full_o from the next cycle. An in_served_i pulse while the buffer is empty has no effect. Validating a buffer that is already full leaves it full, and a single in_served_i pulse still clears it.
- R4: When a 0xFA strobe and an in_served_i pulse arrive in the same cycle, buf_full_o is 1 afterwards.
- R5: An sof_i pulse captures sof_frame_i. After command byte 0xF5, rd_data_o shows frame bits 7:0 until the first rd_i strobe.
- R6: After the first rd_i strobe, rd_data_o shows frame bits 10:8 in bits 2:0, with bits 7:3 at zero. The second rd_i strobe ends the phase and returns rd_data_o to 0.
- R7: The frame value read out is the value held when 0xF5 was accepted. An SOF between the two reads does not change it, and the next 0xF5 returns the new frame.
- R8: Any new command byte ends a pending frame read. A reader may stop after one byte, and later rd_i strobes return 0.
- R9: An unknown command code leaves buf_full_o unchanged. It also ends any pending data phase.
- R10: rd_i with no data phase pending has no effect, and rd_data_o stays 0.
- R11: An SOF in the same cycle as the 0xF5 strobe is not included in that read. The read returns the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Command byte strobe |
| cmd_i | input | 8 | Command byte |
| rd_i | input | 1 | Data read strobe; advances the data phase |
| rd_data_o | output | 8 | Read data byte for the current data phase |
| sof_i | input | 1 | Good SOF received pulse |
| sof_frame_i | input | 11 | Frame number carried with sof_i |
| in_served_i | input | 1 | IN token served pulse |
| buf_full_o | output | 1 | IN buffer full flag |

## Verification
The assertions assume that every strobe and pulse is high for exactly one cycle. They also assume that the data byte is sampled on the same edge as the rd_i strobe, with no wait-states. The bench drives every input on the falling edge and holds each pulse for a single cycle. It places coincident events, such as SOF with 0xF5 or validate with in_served, in one chosen cycle on purpose. The corner cases are probed that way rather than by overlapping pulses at random.

// File: rtl/usb_cmd_pkg.sv
package usb_cmd_pkg;
  localparam logic [7:0] CMD_VALIDATE = 8'hFA;
  localparam logic [7:0] CMD_FRAME    = 8'hF5;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2
  } phase_e;
endpackage

// File: rtl/usb_cmd_decode.sv
module usb_cmd_decode
  import usb_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_wr_i,
  input  logic [7:0] cmd_i,
  input  logic       rd_i,
  output logic       validate_o,
  output logic       snap_o,
  output phase_e     phase_o
);
  phase_e phase_q, phase_d;

  assign validate_o = cmd_wr_i && (cmd_i == CMD_VALIDATE);
  assign snap_o     = cmd_wr_i && (cmd_i == CMD_FRAME);

  always_comb begin
    phase_d = phase_q;
    if (cmd_wr_i) begin
      // any command byte aborts a pending phase
      phase_d = snap_o ? PH_LO : PH_IDLE;
    end else if (rd_i) begin
      unique case (phase_q)
        PH_LO:   phase_d = PH_HI;
        PH_HI:   phase_d = PH_IDLE;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R6
  hi_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HI && rd_i && !cmd_wr_i) |=> phase_q == PH_IDLE);
  // R8
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i != CMD_FRAME) |=> phase_q == PH_IDLE);
  // R10
  idle_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !cmd_wr_i) |=> phase_q == PH_IDLE);
endmodule

// File: rtl/usb_frame_snap.sv
module usb_frame_snap
  import usb_cmd_pkg::*;
#(
  parameter int FRAME_W = 11,
  parameter int DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sof_i,
  input  logic [FRAME_W-1:0] sof_frame_i,
  input  logic               snap_i,
  input  logic               cmd_wr_i,
  input  phase_e             phase_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  localparam int HI_W = FRAME_W - DATA_W;

  logic [FRAME_W-1:0] frame_q, snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      snap_q  <= '0;
    end else begin
      if (sof_i)  frame_q <= sof_frame_i;
      if (snap_i) snap_q  <= frame_q;  // SOF in same cycle not yet visible
    end
  end

  always_comb begin
    unique case (phase_i)
      PH_LO:   rd_data_o = snap_q[DATA_W-1:0];
      PH_HI:   rd_data_o = {{(DATA_W-HI_W){1'b0}}, snap_q[FRAME_W-1:DATA_W]};
      default: rd_data_o = '0;
    endcase
  end

  // R7
  snap_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_wr_i) |=> $stable(snap_q));
  // R6
  hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_HI) |-> (rd_data_o[DATA_W-1:HI_W] == '0));
  // R10
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_IDLE) |-> (rd_data_o == '0));
endmodule

// File: rtl/usb_inbuf_flag.sv
module usb_inbuf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic validate_i,
  input  logic in_served_i,
  output logic full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          full_o <= 1'b0;
    else if (validate_i)  full_o <= 1'b1;  // validate wins over served
    else if (in_served_i) full_o <= 1'b0;
  end

  // R2
  set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(validate_i));
  // R3
  clr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> $past(in_served_i));
  // R4
  both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (validate_i && in_served_i) |=> full_o);
endmodule

// File: rtl/usb_cmd_interp.sv
module usb_cmd_interp
  import usb_cmd_pkg::*;
#(
  parameter int FRAME_W = 11,
  parameter int DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_wr_i,
  input  logic [DATA_W-1:0]  cmd_i,
  input  logic               rd_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic               sof_i,
  input  logic [FRAME_W-1:0] sof_frame_i,
  input  logic               in_served_i,
  output logic               buf_full_o
);
  logic   validate, snap;
  phase_e phase;

  usb_cmd_decode u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (cmd_wr_i),
    .cmd_i      (cmd_i),
    .rd_i       (rd_i),
    .validate_o (validate),
    .snap_o     (snap),
    .phase_o    (phase)
  );

  usb_frame_snap #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sof_i       (sof_i),
    .sof_frame_i (sof_frame_i),
    .snap_i      (snap),
    .cmd_wr_i    (cmd_wr_i),
    .phase_i     (phase),
    .rd_data_o   (rd_data_o)
  );

  usb_inbuf_flag u_inbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .validate_i  (validate),
    .in_served_i (in_served_i),
    .full_o      (buf_full_o)
  );

  // R9
  unknown_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i != CMD_VALIDATE && !in_served_i) |=> $stable(buf_full_o));
endmodule

// File: tb/usb_cmd_interp_tb.sv
module usb_cmd_interp_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_wr_i = 1'b0;
  logic [7:0]  cmd_i = '0;
  logic        rd_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        sof_i = 1'b0;
  logic [10:0] sof_frame_i = '0;
  logic        in_served_i = 1'b0;
  logic        buf_full_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  usb_cmd_interp u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    @(negedge clk_i); cmd_wr_i = 1'b1; cmd_i = c;
    @(negedge clk_i); cmd_wr_i = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk_i); rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic sof(input logic [10:0] f);
    @(negedge clk_i); sof_i = 1'b1; sof_frame_i = f;
    @(negedge clk_i); sof_i = 1'b0;
  endtask

  task automatic served();
    @(negedge clk_i); in_served_i = 1'b1;
    @(negedge clk_i); in_served_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 buf_full", buf_full_o, 0);
    chk("R1 rd_data", rd_data_o, 0);
    cmd(8'hF5);
    chk("R1 frame lo", rd_data_o, 0);
    rd_pulse();
    chk("R1 frame hi", rd_data_o, 0);
    rd_pulse();
  endtask

  task automatic t_validate();
    cmd(8'hFA);
    chk("R2 full set", buf_full_o, 1);
    chk("R2 no phase", rd_data_o, 0);
    rd_pulse();
    chk("R2 rd ignored", rd_data_o, 0);
    cmd(8'hFA);
    chk("R3 revalidate", buf_full_o, 1);
    served();
    chk("R3 cleared", buf_full_o, 0);
    served();
    chk("R3 served empty", buf_full_o, 0);
  endtask

  task automatic t_coincide();
    @(negedge clk_i); cmd_wr_i = 1'b1; cmd_i = 8'hFA; in_served_i = 1'b1;
    @(negedge clk_i); cmd_wr_i = 1'b0; in_served_i = 1'b0;
    chk("R4 validate wins", buf_full_o, 1);
    served();
    chk("R4 then cleared", buf_full_o, 0);
  endtask

  task automatic t_frame();
    sof(11'h5A3);
    cmd(8'hF5);
    chk("R5 lo byte", rd_data_o, 8'hA3);
    rd_pulse();
    chk("R6 hi byte", rd_data_o, 8'h05);
    rd_pulse();
    chk("R6 end", rd_data_o, 0);
    rd_pulse();
    chk("R10 idle rd", rd_data_o, 0);
    sof(11'h7FF);
    cmd(8'hF5);
    chk("R5 lo ff", rd_data_o, 8'hFF);
    rd_pulse();
    chk("R6 hi 7", rd_data_o, 8'h07);
    rd_pulse();
  endtask

  task automatic t_snapshot();
    sof(11'h123);
    cmd(8'hF5);
    sof(11'h456);
    chk("R7 lo held", rd_data_o, 8'h23);
    rd_pulse();
    sof(11'h789);
    chk("R7 hi held", rd_data_o, 8'h01);
    rd_pulse();
    cmd(8'hF5);
    chk("R7 new lo", rd_data_o, 8'h89);
    rd_pulse();
    chk("R7 new hi", rd_data_o, 8'h07);
    rd_pulse();
  endtask

  task automatic t_abort();
    cmd(8'hF5);
    chk("R8 lo", rd_data_o, 8'h89);
    rd_pulse();
    cmd(8'hFA);
    chk("R8 aborted", rd_data_o, 0);
    rd_pulse();
    chk("R8 rd after abort", rd_data_o, 0);
    cmd(8'h33);
    chk("R9 full kept", buf_full_o, 1);
    cmd(8'hF5);
    cmd(8'h00);
    chk("R9 phase ended", rd_data_o, 0);
    served();
    cmd(8'h77);
    chk("R9 empty kept", buf_full_o, 0);
  endtask

  task automatic t_sof_same();
    @(negedge clk_i); cmd_wr_i = 1'b1; cmd_i = 8'hF5; sof_i = 1'b1; sof_frame_i = 11'h2EE;
    @(negedge clk_i); cmd_wr_i = 1'b0; sof_i = 1'b0;
    chk("R11 old lo", rd_data_o, 8'h89);
    rd_pulse();
    chk("R11 old hi", rd_data_o, 8'h07);
    cmd(8'hF5);
    chk("R11 next lo", rd_data_o, 8'hEE);
    rd_pulse();
    chk("R11 next hi", rd_data_o, 8'h02);
    rd_pulse();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_validate();
    t_coincide();
    t_frame();
    t_snapshot();
    t_abort();
    t_sof_same();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule